// File: doc/BRIEF.md
# Complementary Output Dead-Band Generator with Fault Safing

This block turns up to three single-ended PWM streams into complementary pairs suitable for driving half-bridges. For each stream it produces a primary pin and a complementary pin. When a stream rises, the complementary pin is switched off at once, and the primary pin is switched on only after a programmable rise gap. When a stream falls, the primary pin is switched off at once, and the complementary pin follows after a separate fall gap. Both gaps are counted in dead-band ticks. The tick is the core clock divided by a power of two. A cleared run bit bypasses the generator, so the PWM streams appear unchanged on the primary pins.

A fault monitor watches four sources: processor lockup, debug halt and two external event lines. Each source has its own enable. An enabled source latches a flag that only a write-one-to-clear register removes. While any flag is held, a programmed safe action is applied to every enabled pin: the pin goes to its idle level, is driven low, or is released to high impedance. The action can also be set to none. Optionally, the debug-halt flag drops by itself once the halt ends, so the outputs resume without software. A key-based lock freezes the configuration registers.

Top module: `deadband_unit`

## Requirements
- R1: With the run bit (register 0 bit 0) cleared, primary pin i equals pwm_in[i] in the same cycle. The complementary pins are 0 and all output enables are 1. This is also the reset state.
- R2: With run set, prescale exponent p (register 0 bits 6:4) and rise count R (register 1 bits 7:0), a rising pwm_in makes the complementary pin inactive on the first clock edge. The primary pin becomes active on edge R*2^p+1.
- R3: With fall count F (register 1 bits 15:8), a falling pwm_in makes the primary pin inactive on the first edge. The complementary pin becomes active on edge F*2^p+1.
- R4: A pwm pulse that ends before its rise gap has elapsed never makes the primary pin active.
- R5: The gap in clock cycles scales as the count times 2^p. A count of 0 gives no gap.
- R6: Register 0 bit 1 makes the primary pins active low. Register 0 bit 2 inverts the complementary pins.
- R7: Register 2 bits 5:0 enable the pins: bit i enables primary i and bit 3+i enables complementary i. A disabled pin has its output enable at 0 and drives 0.
- R8: Register 3 bits 3:0 enable the fault sources (bit 0 lockup, bit 1 halt, bit 2 event 0, bit 3 event 1). An enabled source that is high at a clock edge sets its flag from that edge on. A disabled source sets nothing. Flags clear only when a 1 is written to the same bit of register 4.
- R9: While any flag is set, register 3 bits 5:4 choose the action for enabled pins: 0 none, 1 idle level, 2 driven low, 3 output enable off.
- R10: With auto-restart (register 0 bit 3) set, the halt flag clears on the first edge at which the halt input is low.
- R11: Writing 16'hC3A5 to register 5 locks registers 0 to 3 against writes. Writing 16'h3C5A to register 5 unlocks them.
- R12: While running with no fault action, no channel has its primary and complementary pins active at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwm_in | input | 3 | PWM streams, one per channel |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register index |
| cfg_wdata | input | 16 | Register write data |
| flt_lockup | input | 1 | Processor lockup fault source |
| flt_halt | input | 1 | Debug halt fault source |
| flt_ext | input | 2 | External event fault sources |
| pin_out | output | 6 | Pin levels: [2:0] primary, [5:3] complementary |
| pin_oe | output | 6 | Pin output enables, same order |
| fault_flags | output | 4 | Sticky fault flags |

## Verification
The assertions check on every cycle that the pins of one channel are never both active, and that both pins are off right after an edge with a nonzero gap. They also check that flags stay set until cleared, that the halt flag drops under auto-restart, that locked registers hold still, and that the tristate action removes every output enable. Only the bench scenarios can show the exact gap lengths under different prescale settings, the swallowing of short pulses, the polarity options and the mask. The same holds for the choice among the four safe actions and the key sequences that lock and unlock the registers.

// File: rtl/deadband_pkg.sv
`timescale 1ns/1ps
package deadband_pkg;
  localparam int REG_W  = 16;
  localparam int ADDR_W = 3;
  localparam int PS_W   = 3;
  localparam int NSRC   = 4;
  localparam int SRC_HALT = 1;

  localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
  localparam logic [ADDR_W-1:0] A_TIME  = 3'd1;
  localparam logic [ADDR_W-1:0] A_OUTEN = 3'd2;
  localparam logic [ADDR_W-1:0] A_FCFG  = 3'd3;
  localparam logic [ADDR_W-1:0] A_FCLR  = 3'd4;
  localparam logic [ADDR_W-1:0] A_LOCK  = 3'd5;

  localparam logic [REG_W-1:0] KEY_LOCK = 16'hC3A5;
  localparam logic [REG_W-1:0] KEY_OPEN = 16'h3C5A;

  typedef enum logic [1:0] {
    SAFE_NONE = 2'd0,
    SAFE_IDLE = 2'd1,
    SAFE_LOW  = 2'd2,
    SAFE_HIZ  = 2'd3
  } safe_act_e;

  // bit 0 run, bit 1 primary active low, bit 2 complementary invert,
  // bit 3 auto restart, bits 6:4 prescale exponent
  typedef struct packed {
    logic [PS_W-1:0] presc;
    logic            auto_rst;
    logic            comp_inv;
    logic            prim_low;
    logic            run;
  } ctrl_t;

  // gap length in core cycles for a tick count and a prescale exponent
  function automatic int unsigned dead_cycles(input int unsigned ticks,
                                              input int unsigned exp2);
    return ticks << exp2;
  endfunction

  // returns {output enable, level} for one pin
  function automatic logic [1:0] drive_pin(input logic active, input logic inv,
                                           input logic on, input logic safing,
                                           input safe_act_e act);
    if (!on) return 2'b00;
    if (safing) begin
      case (act)
        SAFE_IDLE: return {1'b1, inv};
        SAFE_LOW:  return 2'b10;
        SAFE_HIZ:  return 2'b00;
        default:   return {1'b1, active ^ inv};
      endcase
    end
    return {1'b1, active ^ inv};
  endfunction
endpackage

// File: rtl/deadband_regs.sv
`timescale 1ns/1ps
module deadband_regs
  import deadband_pkg::*;
#(
  parameter int NCH  = 3,
  parameter int DT_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [REG_W-1:0]      wdata,
  output ctrl_t                 ctrl,
  output logic [DT_W-1:0]       rise_ticks,
  output logic [DT_W-1:0]       fall_ticks,
  output logic [2*NCH-1:0]      outen,
  output logic [NSRC-1:0]       src_en,
  output safe_act_e             action,
  output logic [NSRC-1:0]       clr_pulse,
  output logic                  locked
);
  logic cfg_hit;
  assign cfg_hit   = we && !locked && (addr <= A_FCFG);
  assign clr_pulse = (we && addr == A_FCLR) ? wdata[NSRC-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl       <= '0;
      rise_ticks <= '0;
      fall_ticks <= '0;
      outen      <= '0;
      src_en     <= '0;
      action     <= SAFE_NONE;
      locked     <= 1'b0;
    end else begin
      if (we && addr == A_LOCK) begin
        if (wdata == KEY_LOCK)      locked <= 1'b1;
        else if (wdata == KEY_OPEN) locked <= 1'b0;
      end
      if (cfg_hit) begin
        case (addr)
          A_CTRL:  ctrl <= ctrl_t'(wdata[$bits(ctrl_t)-1:0]);
          A_TIME:  begin
                     rise_ticks <= wdata[DT_W-1:0];
                     fall_ticks <= wdata[2*DT_W-1:DT_W];
                   end
          A_OUTEN: outen <= wdata[2*NCH-1:0];
          A_FCFG:  begin
                     src_en <= wdata[NSRC-1:0];
                     action <= safe_act_e'(wdata[NSRC+1:NSRC]);
                   end
          default: ;
        endcase
      end
    end
  end

  p_lock_holds_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && we && addr <= A_FCFG && !(addr == A_LOCK))
      |=> ($stable(ctrl) && $stable(outen) && $stable(rise_ticks) &&
           $stable(fall_ticks) && $stable(src_en) && $stable(action)))
    else $error("locked configuration changed");
endmodule

// File: rtl/deadband_fault.sv
`timescale 1ns/1ps
module deadband_fault
  import deadband_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src,
  input  logic [NSRC-1:0] src_en,
  input  logic [NSRC-1:0] clr,
  input  logic            auto_rst,
  output logic [NSRC-1:0] flags
);
  logic [NSRC-1:0] hit, keep;
  assign hit = src & src_en;

  always_comb begin
    keep = flags & ~clr;
    if (auto_rst && !src[SRC_HALT]) keep[SRC_HALT] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) flags <= '0;
    else        flags <= hit | keep;
  end

  for (genvar k = 0; k < NSRC; k++) begin : g_chk
    p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (flags[k] && !clr[k] && !(k == SRC_HALT && auto_rst)) |=> flags[k])
      else $error("flag %0d dropped without clear", k);
    p_flag_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flags[k]) |-> $past(src[k] && src_en[k]))
      else $error("flag %0d set without enabled source", k);
  end

  p_auto_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_rst && !src[SRC_HALT]) |=> !flags[SRC_HALT])
    else $error("halt flag held under auto restart");
endmodule

// File: rtl/deadband_chan.sv
`timescale 1ns/1ps
module deadband_chan #(
  parameter int CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwm,
  input  logic [CNT_W-1:0] load_rise,
  input  logic [CNT_W-1:0] load_fall,
  output logic             p_act,
  output logic             c_act
);
  logic             lvl;
  logic [CNT_W-1:0] cnt;
  logic             toggled, settled;

  assign toggled = pwm ^ lvl;
  assign settled = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl <= 1'b0;
      cnt <= '0;
    end else if (toggled) begin
      lvl <= pwm;
      cnt <= pwm ? load_rise : load_fall;
    end else if (!settled) begin
      cnt <= cnt - CNT_W'(1);
    end
  end

  assign p_act = lvl & settled;
  assign c_act = ~lvl & settled;

  p_gap_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (toggled && pwm && load_rise != '0) |=> (!p_act && !c_act))
    else $error("no gap after rising edge");
  p_gap_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (toggled && !pwm && load_fall != '0) |=> (!p_act && !c_act))
    else $error("no gap after falling edge");
endmodule

// File: rtl/deadband_unit.sv
`timescale 1ns/1ps
module deadband_unit
  import deadband_pkg::*;
#(
  parameter int NCH  = 3,
  parameter int DT_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NCH-1:0]      pwm_in,
  input  logic                cfg_we,
  input  logic [ADDR_W-1:0]   cfg_addr,
  input  logic [REG_W-1:0]    cfg_wdata,
  input  logic                flt_lockup,
  input  logic                flt_halt,
  input  logic [1:0]          flt_ext,
  output logic [2*NCH-1:0]    pin_out,
  output logic [2*NCH-1:0]    pin_oe,
  output logic [NSRC-1:0]     fault_flags
);
  localparam int CNT_W = DT_W + (1 << PS_W) - 1;

  ctrl_t           ctrl;
  logic [DT_W-1:0] rise_ticks, fall_ticks;
  logic [2*NCH-1:0] outen;
  logic [NSRC-1:0] src_en, clr_pulse, src;
  safe_act_e       action;
  logic            locked;
  logic            safing;
  logic [CNT_W-1:0] load_rise, load_fall;
  logic [NCH-1:0]  p_act, c_act, prim_lv, prim_oe, comp_lv, comp_oe;

  deadband_regs #(.NCH(NCH), .DT_W(DT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .ctrl(ctrl), .rise_ticks(rise_ticks), .fall_ticks(fall_ticks),
    .outen(outen), .src_en(src_en), .action(action),
    .clr_pulse(clr_pulse), .locked(locked)
  );

  assign src = {flt_ext[1], flt_ext[0], flt_halt, flt_lockup};

  deadband_fault u_fault (
    .clk(clk), .rst_n(rst_n), .src(src), .src_en(src_en), .clr(clr_pulse),
    .auto_rst(ctrl.auto_rst), .flags(fault_flags)
  );

  assign safing    = (|fault_flags) && (action != SAFE_NONE);
  assign load_rise = CNT_W'(dead_cycles(32'(rise_ticks), 32'(ctrl.presc)));
  assign load_fall = CNT_W'(dead_cycles(32'(fall_ticks), 32'(ctrl.presc)));

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    deadband_chan #(.CNT_W(CNT_W)) u_ch (
      .clk(clk), .rst_n(rst_n), .pwm(pwm_in[c]),
      .load_rise(load_rise), .load_fall(load_fall),
      .p_act(p_act[c]), .c_act(c_act[c])
    );
    assign {prim_oe[c], prim_lv[c]} =
      drive_pin(p_act[c], ctrl.prim_low, outen[c], safing, action);
    assign {comp_oe[c], comp_lv[c]} =
      drive_pin(c_act[c], ctrl.comp_inv, outen[NCH+c], safing, action);

    p_no_overlap_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl.run && !safing) |->
        !(pin_oe[c] && pin_oe[NCH+c] &&
          (pin_out[c] ^ ctrl.prim_low) && (pin_out[NCH+c] ^ ctrl.comp_inv)))
      else $error("channel %0d pins both active", c);
  end

  always_comb begin
    if (!ctrl.run) begin
      pin_out = {{NCH{1'b0}}, pwm_in};
      pin_oe  = '1;
    end else begin
      pin_out = {comp_lv, prim_lv};
      pin_oe  = {comp_oe, prim_oe};
    end
  end

  p_hiz_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.run && (|fault_flags) && action == SAFE_HIZ) |-> (pin_oe == '0))
    else $error("tristate action left a pin enabled");
endmodule

// File: tb/deadband_unit_test.sv
`timescale 1ns/1ps
module deadband_unit_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] pwm_in = '0;
  logic       cfg_we = 1'b0;
  logic [2:0] cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic       flt_lockup = 1'b0, flt_halt = 1'b0;
  logic [1:0] flt_ext = '0;
  logic [5:0] pin_out, pin_oe;
  logic [3:0] fault_flags;

  int checks = 0, errors = 0;
  int sb_q[$];
  bit done = 0;
  logic plow = 1'b0, cinv = 1'b0;

  always #2.5 clk = ~clk;

  deadband_unit uut (
    .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .flt_lockup(flt_lockup),
    .flt_halt(flt_halt), .flt_ext(flt_ext), .pin_out(pin_out),
    .pin_oe(pin_oe), .fault_flags(fault_flags)
  );

  // driver side: expected results enter the scoreboard
  task automatic sb_expect(input int e);
    sb_q.push_back(e);
  endtask

  // monitor side: observed results are compared in order
  task automatic sb_observe(input string tag, input int got);
    int e;
    e = sb_q.pop_front();
    checks++;
    if (got != e) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, got, e);
    end
  endtask

  task automatic check(input string tag, input int got, input int e);
    sb_expect(e);
    sb_observe(tag, got);
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // raise one stream, return the edge count at which its primary turns active
  task automatic rise_gap(input int ch, output int d, output int comp1, output int ovl);
    pwm_in[ch] = 1'b1; d = -1; comp1 = -1; ovl = 0;
    for (int j = 1; j <= 5000; j++) begin
      @(posedge clk); @(negedge clk);
      if (j == 1) comp1 = int'(pin_out[3+ch] ^ cinv);
      if ((pin_out[ch] ^ plow) && (pin_out[3+ch] ^ cinv)) ovl++;
      if (pin_out[ch] ^ plow) begin d = j; break; end
    end
  endtask

  task automatic fall_gap(input int ch, output int d, output int prim1);
    pwm_in[ch] = 1'b0; d = -1; prim1 = -1;
    for (int j = 1; j <= 5000; j++) begin
      @(posedge clk); @(negedge clk);
      if (j == 1) prim1 = int'(pin_out[ch] ^ plow);
      if (pin_out[3+ch] ^ cinv) begin d = j; break; end
    end
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog R1..: actual hang expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int d, a1, ov, cnt;
    wait_cyc(4);
    // R1 reset state: bypass, all enables on, no flags
    check("R1 reset oe", int'(pin_oe), 6'h3F);
    check("R1 reset out", int'(pin_out), 0);
    check("R8 reset flags", int'(fault_flags), 0);
    rst_n = 1'b1;
    wait_cyc(1);
    pwm_in = 3'b101; #1;
    check("R1 bypass", int'(pin_out), 6'b000101);
    pwm_in = 3'b000;

    wr(3'd1, 16'h0204);        // rise 4, fall 2
    wr(3'd2, 16'h003F);
    wr(3'd0, 16'h0001);
    wait_cyc(10);
    check("R6 idle levels default polarity", int'(pin_out), 6'b111000);

    sb_expect(5);
    rise_gap(0, d, a1, ov);
    sb_observe("R2 rise gap ch0", d);
    check("R2 comp off first edge", a1, 0);
    check("R12 no overlap on rise", ov, 0);
    sb_expect(3);
    fall_gap(0, d, a1);
    sb_observe("R3 fall gap ch0", d);
    check("R3 primary off first edge", a1, 0);

    wr(3'd1, 16'h0200);        // rise 0
    sb_expect(1);
    rise_gap(1, d, a1, ov);
    sb_observe("R5 zero gap ch1", d);

    wr(3'd1, 16'h0203);        // rise 3
    wr(3'd0, 16'h0021);        // prescale exponent 2
    sb_expect(13);
    rise_gap(2, d, a1, ov);
    sb_observe("R5 prescaled gap ch2", d);
    check("R12 no overlap prescaled", ov, 0);
    pwm_in = 3'b000;
    wait_cyc(20);
    wr(3'd0, 16'h0001);

    wr(3'd1, 16'h020A);        // rise 10
    pwm_in[0] = 1'b1;
    cnt = 0;
    for (int j = 0; j < 30; j++) begin
      @(negedge clk);
      if (j == 3) pwm_in[0] = 1'b0;
      if (pin_out[0]) cnt++;
    end
    check("R4 short pulse swallowed", cnt, 0);
    check("R4 comp back after pulse", int'(pin_out[3]), 1);

    wr(3'd0, 16'h0007); plow = 1'b1; cinv = 1'b1;
    wait_cyc(1);
    check("R6 primary idle high", int'(pin_out[0]), 1);
    check("R6 comp inverted active", int'(pin_out[3]), 0);
    pwm_in[1] = 1'b1;
    wait_cyc(13);
    check("R6 primary active low", int'(pin_out[1]), 0);
    wr(3'd0, 16'h0001); plow = 1'b0; cinv = 1'b0;

    wr(3'd2, 16'h0002);
    wait_cyc(1);
    check("R7 mask oe", int'(pin_oe), 6'b000010);
    check("R7 mask levels", int'(pin_out), 6'b000010);
    wr(3'd2, 16'h003F);
    wait_cyc(1);
    check("R9 normal levels", int'(pin_out), 6'b101010);

    wr(3'd3, 16'h0011);        // lockup only, idle action
    flt_ext[0] = 1'b1; wait_cyc(1); flt_ext[0] = 1'b0; wait_cyc(1);
    check("R8 disabled source ignored", int'(fault_flags), 0);
    check("R8 disabled source no safing", int'(pin_out), 6'b101010);
    flt_lockup = 1'b1; wait_cyc(1); flt_lockup = 1'b0; wait_cyc(4);
    check("R8 flag sticky", int'(fault_flags), 1);
    check("R9 idle action", int'(pin_out), 0);
    wr(3'd0, 16'h0003);
    wait_cyc(1);
    check("R9 idle action active low", int'(pin_out), 6'b000111);
    wr(3'd3, 16'h0021);
    wait_cyc(1);
    check("R9 low action", int'(pin_out), 0);
    check("R9 low action oe", int'(pin_oe), 6'h3F);
    wr(3'd3, 16'h0031);
    wait_cyc(1);
    check("R9 tristate action", int'(pin_oe), 0);
    wr(3'd3, 16'h0001);
    wait_cyc(1);
    check("R9 none action", int'(pin_out), 6'b101101);
    wr(3'd0, 16'h0001);
    wr(3'd4, 16'h0001);
    wait_cyc(1);
    check("R8 write one clears", int'(fault_flags), 0);

    wr(3'd3, 16'h0032);        // halt only, tristate
    wr(3'd0, 16'h0009);        // run + auto restart
    flt_halt = 1'b1; wait_cyc(2);
    check("R10 halt flag", int'(fault_flags), 2);
    check("R10 halted outputs off", int'(pin_oe), 0);
    flt_halt = 1'b0; wait_cyc(1);
    check("R10 auto release", int'(fault_flags), 0);
    check("R10 outputs resume", int'(pin_oe), 6'h3F);
    wr(3'd0, 16'h0001);
    flt_halt = 1'b1; wait_cyc(2); flt_halt = 1'b0; wait_cyc(2);
    check("R10 no auto keeps flag", int'(fault_flags), 2);
    wr(3'd4, 16'h0002);
    wait_cyc(1);
    check("R8 halt flag cleared", int'(fault_flags), 0);

    wr(3'd5, 16'hC3A5);
    wr(3'd2, 16'h0000);
    wait_cyc(1);
    check("R11 locked write ignored", int'(pin_oe), 6'h3F);
    wr(3'd5, 16'h3C5A);
    wr(3'd2, 16'h0000);
    wait_cyc(1);
    check("R11 unlocked write applies", int'(pin_oe), 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule